// File: doc/BRIEF.md
# Interrupt Eligibility Mask Logic

This block keeps the per-line state of a bank of interrupts: a pending latch, an enable bit, an active bit, a trigger mode, a group bit and a group-modifier bit. It also samples the raw interrupt wires. From that state it produces a registered vector with one bit per line. A bit is set when that line may be presented to a CPU. A small control register gates the vector. It holds three group enables and a security-disable flag.

All state is loaded through one write port. A 3-bit selector picks the bitmap, and a data word carries one bit per line. Two of the selector codes are set and clear strobes for the pending latches. A one-cycle strobe marks each cycle in which the registered vector takes a new value, so that a downstream priority scan can be started only when needed.

Top module: `irq_elig_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `elig_vec` and `elig_chg` are zero. Reset clears every bitmap and the control register, so every line starts level-triggered.
- R2: A line whose trigger bit is 0 counts as pending for exactly as long as its input is high. The vector bit follows the input two clock edges after the input changes, and nothing is latched.
- R3: A rising input on a line whose trigger bit is 1 sets its pending latch. The vector bit rises on the third edge after the input rises, and it stays set after the input falls.
- R4: Writing with selector 5 sets the pending latches where the data bits are 1. Writing with selector 6 clears them where the data bits are 1. Data bits that are 0 leave the latches unchanged.
- R5: A line with its enable bit (selector 0) at 0 never appears in the vector.
- R6: A line with its active bit (selector 1) at 1 never appears in the vector.
- R7: A line with group bit (selector 3) at 1 passes only when control bit 1 is set.
- R8: A line with group bit 0 and modifier bit (selector 4) at 1 passes only when control bit 2 is set and control bit 3 is clear.
- R9: A line with group bit 0 and modifier bit 0 passes only when control bit 0 is set.
- R10: With control bit 3 (security disable) set, every modifier bit is read as 0. A group-0 line with modifier 1 is then gated by control bit 0.
- R11: Selector 2 writes the trigger bits (1 = edge) and selector 7 writes the control bits [3:0]. Any write changes `elig_vec` on the second edge after the write is applied. `elig_chg` is high in exactly the cycles in which `elig_vec` differs from its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the state port |
| wr_sel | input | 3 | Bitmap selector (0 enable, 1 active, 2 trigger, 3 group, 4 modifier, 5 pending set, 6 pending clear, 7 control) |
| wr_data | input | NUM_IRQ | Write data, one bit per line; control uses bits [3:0] |
| irq_in | input | NUM_IRQ | Raw interrupt inputs |
| elig_vec | output | NUM_IRQ | Registered eligibility vector |
| elig_chg | output | 1 | High in the cycle the vector takes a new value |

## Verification
The assertions assume that `irq_in` is synchronous to `clk`. They also assume that the port carries at most one write per cycle, so a set and a clear never reach the same latch through software in one cycle. The stimulus changes inputs only on falling edges and issues single-cycle writes with idle cycles between them. Each edge-triggered test raises an input after its trigger bit has been written. The bench compares the vector against values worked out from the group and modifier encodings. It samples at the cycle counts stated in the requirements.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;
  localparam int CTL_W = 4;

  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_ACTIVE = 3'd1,
    SEL_TRIG   = 3'd2,
    SEL_GROUP  = 3'd3,
    SEL_GMOD   = 3'd4,
    SEL_PSET   = 3'd5,
    SEL_PCLR   = 3'd6,
    SEL_CTRL   = 3'd7
  } wsel_e;

  typedef struct packed {
    logic sec_dis;
    logic g1s_en;
    logic g1ns_en;
    logic g0_en;
  } ctl_t;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] lvl_o,
  output logic [NUM_IRQ-1:0] rise_o
);
  logic [NUM_IRQ-1:0] s1_q;
  logic [NUM_IRQ-1:0] s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= irq_i;
      s2_q <= s1_q;
    end
  end

  assign lvl_o  = s1_q;
  assign rise_o = s1_q & ~s2_q;

  // R3: an edge indication lasts a single cycle per line
  p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
    (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_elig_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_sel_i,
  input  logic [NUM_IRQ-1:0] wr_data_i,
  input  logic [NUM_IRQ-1:0] rise_i,
  output logic [NUM_IRQ-1:0] en_q,
  output logic [NUM_IRQ-1:0] act_q,
  output logic [NUM_IRQ-1:0] trig_q,
  output logic [NUM_IRQ-1:0] grp_q,
  output logic [NUM_IRQ-1:0] mod_q,
  output logic [NUM_IRQ-1:0] pend_q,
  output ctl_t               ctl_q
);
  wsel_e sel;
  logic [NUM_IRQ-1:0] set_v;
  logic [NUM_IRQ-1:0] clr_v;

  assign sel   = wsel_e'(wr_sel_i);
  assign set_v = (rise_i & trig_q) |
                 ((wr_en_i && sel == SEL_PSET) ? wr_data_i : '0);
  assign clr_v = (wr_en_i && sel == SEL_PCLR) ? wr_data_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      act_q  <= '0;
      trig_q <= '0;
      grp_q  <= '0;
      mod_q  <= '0;
      ctl_q  <= '0;
    end else if (wr_en_i) begin
      case (sel)
        SEL_ENABLE: en_q   <= wr_data_i;
        SEL_ACTIVE: act_q  <= wr_data_i;
        SEL_TRIG:   trig_q <= wr_data_i;
        SEL_GROUP:  grp_q  <= wr_data_i;
        SEL_GMOD:   mod_q  <= wr_data_i;
        SEL_CTRL:   ctl_q  <= ctl_t'(wr_data_i[CTL_W-1:0]);
        default: ;
      endcase
    end
  end

  // one latch per line; a set wins over a clear in the same cycle
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (rst)           pend_q[i] <= 1'b0;
      else if (set_v[i]) pend_q[i] <= 1'b1;
      else if (clr_v[i]) pend_q[i] <= 1'b0;
    end
  end

  // R3: an edge on an edge-configured line leaves its latch set
  p_edge_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (|(rise_i & trig_q)) |=>
      ((pend_q & $past(rise_i & trig_q)) == $past(rise_i & trig_q)));

  // R4: bits written with the clear code are low on the next cycle
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel == SEL_PCLR) |=>
      ((pend_q & $past(wr_data_i & ~(rise_i & trig_q))) == '0));
endmodule

// File: rtl/irq_group_gate.sv
module irq_group_gate
  import irq_elig_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] lvl_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] act_i,
  input  logic [NUM_IRQ-1:0] trig_i,
  input  logic [NUM_IRQ-1:0] grp_i,
  input  logic [NUM_IRQ-1:0] mod_i,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  ctl_t               ctl_i,
  output logic [NUM_IRQ-1:0] elig_q,
  output logic               chg_q
);
  logic [NUM_IRQ-1:0] raw;
  logic [NUM_IRQ-1:0] mod_eff;
  logic [NUM_IRQ-1:0] gmask;
  logic [NUM_IRQ-1:0] elig_d;

  always_comb begin
    raw     = (pend_i | (lvl_i & ~trig_i)) & en_i & ~act_i;
    mod_eff = ctl_i.sec_dis ? '0 : mod_i;
    gmask   = '0;
    if (ctl_i.g1ns_en) gmask = gmask | grp_i;
    if (ctl_i.g1s_en)  gmask = gmask | (~grp_i & mod_eff);
    if (ctl_i.g0_en)   gmask = gmask | (~grp_i & ~mod_eff);
    elig_d  = raw & gmask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elig_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      elig_q <= elig_d;
      chg_q  <= (elig_d != elig_q);
    end
  end

  // R6: nothing active in the previous cycle is presented
  p_active_out_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((elig_q & $past(act_i)) == '0));

  // R5: nothing disabled in the previous cycle is presented
  p_enable_out_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((elig_q & ~$past(en_i)) == '0));

  // R9: group-0 lines stay out while the group-0 enable is off
  p_g0_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctl_i.g0_en) |=> ((elig_q & ~$past(grp_i) & ~$past(mod_i)) == '0));

  // R11: the strobe marks exactly the cycles the vector moves
  p_chg_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chg_q == (elig_q != $past(elig_q))));
endmodule

// File: rtl/irq_elig_bank.sv
module irq_elig_bank
  import irq_elig_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [NUM_IRQ-1:0] wr_data,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] elig_vec,
  output logic               elig_chg
);
  logic [NUM_IRQ-1:0] lvl, rise;
  logic [NUM_IRQ-1:0] en_q, act_q, trig_q, grp_q, mod_q, pend_q;
  ctl_t               ctl_q;

  irq_edge_detect #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk(clk), .rst(rst), .irq_i(irq_in), .lvl_o(lvl), .rise_o(rise)
  );

  irq_state_bank #(.NUM_IRQ(NUM_IRQ)) u_state (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rise_i(rise), .en_q(en_q), .act_q(act_q),
    .trig_q(trig_q), .grp_q(grp_q), .mod_q(mod_q), .pend_q(pend_q),
    .ctl_q(ctl_q)
  );

  irq_group_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .clk(clk), .rst(rst), .lvl_i(lvl), .en_i(en_q), .act_i(act_q),
    .trig_i(trig_q), .grp_i(grp_q), .mod_i(mod_q), .pend_i(pend_q),
    .ctl_i(ctl_q), .elig_q(elig_vec), .chg_q(elig_chg)
  );

  // R1: quiet outputs on the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (elig_vec == '0 && !elig_chg));
endmodule

// File: tb/irq_elig_bank_tb.sv
module irq_elig_bank_tb_top;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] irq_in = '0;
  logic [N-1:0] elig_vec;
  logic elig_chg;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_elig_bank #(.NUM_IRQ(N)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .irq_in(irq_in), .elig_vec(elig_vec),
    .elig_chg(elig_chg)
  );

  task automatic chk(input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // write applied on the next rising edge; returns at the falling edge after it
  task automatic wr(input logic [2:0] s, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    tick(2);
    chk("R1 vec in reset", elig_vec, '0);
    rst = 1'b0;
    tick(1);
    chk("R1 vec after reset", elig_vec, '0);
    chk("R1 chg after reset", {31'b0, elig_chg}, '0);
  endtask

  task automatic t_level;
    wr(3'd0, '1);          // enable all
    wr(3'd7, 32'h1);       // group-0 enable
    tick(1);
    irq_in[3] = 1'b1;
    tick(1);
    chk("R2 not yet", elig_vec, '0);
    tick(1);
    chk("R2 level high", elig_vec, 32'h8);
    chk("R11 strobe on change", {31'b0, elig_chg}, 32'h1);
    tick(1);
    chk("R11 strobe one cycle", {31'b0, elig_chg}, '0);
    irq_in[3] = 1'b0;
    tick(2);
    chk("R2 no latch", elig_vec, '0);
  endtask

  task automatic t_edge;
    wr(3'd2, 32'h20);      // line 5 edge-triggered
    tick(1);
    irq_in[5] = 1'b1;
    tick(2);
    chk("R3 before third edge", elig_vec, '0);
    tick(1);
    chk("R3 latched", elig_vec, 32'h20);
    irq_in[5] = 1'b0;
    tick(4);
    chk("R3 held after drop", elig_vec, 32'h20);
    wr(3'd6, 32'h20);
    tick(1);
    chk("R4 clear edge latch", elig_vec, '0);
  endtask

  task automatic t_setclr;
    wr(3'd5, 32'h100);
    tick(1);
    chk("R4 set", elig_vec, 32'h100);
    wr(3'd6, 32'hFFFF_FEFF);
    tick(1);
    chk("R4 zero bits keep", elig_vec, 32'h100);
    chk("R11 no strobe without change", {31'b0, elig_chg}, '0);
  endtask

  task automatic t_en_act;
    wr(3'd0, 32'hFFFF_FEFF);
    tick(1);
    chk("R5 disabled", elig_vec, '0);
    wr(3'd0, '1);
    tick(1);
    chk("R5 enabled", elig_vec, 32'h100);
    wr(3'd1, 32'h100);
    tick(1);
    chk("R6 active", elig_vec, '0);
    wr(3'd1, '0);
    tick(1);
    chk("R6 inactive", elig_vec, 32'h100);
    wr(3'd6, 32'h100);
    tick(1);
    chk("R4 clear", elig_vec, '0);
  endtask

  task automatic t_groups;
    wr(3'd3, 32'h1);       // line 0 group 1
    wr(3'd4, 32'h2);       // line 1 modifier 1
    wr(3'd5, 32'h7);
    tick(1);
    chk("R9 group0 only", elig_vec, 32'h4);
    wr(3'd7, 32'h2);
    tick(1);
    chk("R7 group1 nonsecure", elig_vec, 32'h1);
    wr(3'd7, 32'h4);
    tick(1);
    chk("R8 group1 secure", elig_vec, 32'h2);
    wr(3'd7, 32'h7);
    tick(1);
    chk("R7 R8 R9 all", elig_vec, 32'h7);
    wr(3'd7, 32'h0);
    tick(1);
    chk("R9 none enabled", elig_vec, '0);
    wr(3'd7, 32'h9);
    tick(1);
    chk("R10 modifier forced zero", elig_vec, 32'h6);
    wr(3'd7, 32'hC);
    tick(1);
    chk("R8 R10 secure blocked", elig_vec, '0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_setclr();
    t_en_act();
    t_groups();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule